// File: doc/BRIEF.md
# Packet transmit FIFO with discard

This block buffers outgoing frames between a system-side writer and a transmit engine. The writer pushes 32-bit double words, each with four byte-enable bits, a frame-boundary marker and a request to suppress the frame check sequence. All of these are sampled on the rising edge of one system clock. The read side pops stored words in order. Each word comes with its byte enables and a marker for the last word of the frame. On the last word it also carries a tag saying whether the transmitter should skip appending the CRC.

Frames are held back from the read side until they are complete. If an error is flagged while a frame is being written, every word of that frame already in storage is dropped. A sticky discard flag is then raised and the write side stays locked until a clear strobe arrives. Frames that were already complete are not touched. A write that arrives when storage is full inside a frame is handled as the same kind of error.

Two fullness indications are provided. The first is a ready flag that compares the free space with a programmable threshold. The second is a fixed flag that is high while more than two words of space remain.

Top module: `txpkt_fifo`

## Requirements
- R1: After synchronous reset the storage is empty: `rd_valid` and `discard` are low, and the free space equals the full depth.
- R2: Every stored word comes back on the read side unchanged and in write order, with its data and byte enables. Bit 3 of the byte enables qualifies data bits 31:24, bit 2 qualifies 23:16, bit 1 qualifies 15:8 and bit 0 qualifies 7:0.
- R3: A frame begins with a word written with `wr_eof` high while no frame is open, and it ends with the next word written with `wr_eof` high. A word written with `wr_eof` low while no frame is open is ignored. No word of a frame is visible on the read side before its closing word has been written, and `rd_last` is high only on that closing word.
- R4: `rd_crc_off` on a closing word is the OR of three things: `cfg_crc_off`, any `wr_nocrc` seen on the opening word, and any `wr_nocrc` seen on any later cycle up to and including the closing word, whether or not a write happens in that cycle. `rd_crc_off` is 0 on every other word.
- R5: When `wr_err` is high in a cycle where a frame is open, or together with an opening word, the words of that frame already in storage are removed and the word of that cycle is not stored. `discard` rises on the next edge. Complete frames stay readable and their space stays used.
- R6: While `discard` is high, every write is ignored and changes neither the contents nor the free space. `clr_discard` lowers `discard` on the next edge, and a write in that same cycle is also ignored.
- R7: `tx_ready` is high exactly when the free space, counted including words of an open frame, is greater than `ready_thresh`.
- R8: `space_avail` is high exactly when more than two words of free space remain.
- R9: A write inside an open frame while the storage is full is treated as an error, as in R5, and the used count never exceeds the depth.
- R10: A pop in the same cycle as an error flush still removes exactly one complete word from the read side. The flush leaves the read position untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_crc_off | input | 1 | Suppress CRC for every frame |
| ready_thresh | input | $clog2(DEPTH)+1 | Free-space threshold for `tx_ready` |
| clr_discard | input | 1 | Clears the discard flag and unlocks writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data word |
| wr_be | input | 4 | Byte enables for `wr_data` |
| wr_eof | input | 1 | Frame boundary marker (first and last word) |
| wr_nocrc | input | 1 | CRC suppress request for the open frame |
| wr_err | input | 1 | Error on the frame being written |
| rd_en | input | 1 | Pop the head word |
| rd_valid | output | 1 | A complete word is available |
| rd_data | output | 32 | Head word data |
| rd_be | output | 4 | Head word byte enables |
| rd_last | output | 1 | Head word closes its frame |
| rd_crc_off | output | 1 | Skip CRC for the frame closed by this word |
| tx_ready | output | 1 | Free space above threshold |
| space_avail | output | 1 | More than two words free |
| discard | output | 1 | Sticky error flag; writes locked |

## Verification
An error flush moves the write position back, while a pop in the same cycle moves the read position forward. Both act on the used count at one edge. The bench provokes this by opening a second frame behind a complete one and then raising `wr_err` and `rd_en` together. It judges the outcome in two ways. The head word that was popped is compared with the first word of the complete frame. A threshold sweep of `tx_ready` then recovers the exact free space, which must equal the depth minus the remaining words of the complete frame. The same sweep follows every frame, flush, locked write and clear with write, across a depth-8 configuration.

// File: rtl/txpkt_pkg.sv
package txpkt_pkg;

    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    typedef struct packed {
        logic              crc_off;
        logic              last;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] data;
    } entry_t;

    // CRC suppression tag for a closing word
    function automatic logic crc_tag(input logic cfg_off,
                                     input logic seen,
                                     input logic now);
        return cfg_off | seen | now;
    endfunction

endpackage

// File: rtl/txpkt_store.sv
module txpkt_store
    import txpkt_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  entry_t        wentry,
    input  logic [AW-1:0] raddr,
    output entry_t        rentry
);

    entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wentry;
        end
    end

    assign rentry = mem[raddr];

endmodule

// File: rtl/txpkt_wr_ctrl.sv
module txpkt_wr_ctrl
    import txpkt_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int PW    = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_crc_off,
    input  logic              clr_discard,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BE_W-1:0]   wr_be,
    input  logic              wr_eof,
    input  logic              wr_nocrc,
    input  logic              wr_err,
    input  logic              full,
    output logic              mem_we,
    output logic [PW-2:0]     mem_waddr,
    output entry_t            mem_entry,
    output logic [PW-1:0]     wr_ptr,
    output logic [PW-1:0]     commit_ptr,
    output logic              discard
);

    logic          in_pkt;
    logic          crc_seen;
    logic [PW-1:0] wr_ptr_q;
    logic [PW-1:0] commit_q;
    logic          discard_q;

    logic open_cyc;   // a frame is open or is being opened this cycle
    logic take;       // write would be accepted
    logic fail;       // error or overflow flush
    logic store;
    logic close;

    always_comb begin
        open_cyc = !discard_q && (in_pkt || (wr_en && wr_eof));
        take     = !discard_q && wr_en && (in_pkt || wr_eof);
        fail     = open_cyc && (wr_err || (take && full));
        store    = take && !fail;
        close    = store && in_pkt && wr_eof;
    end

    always_comb begin
        mem_we            = store;
        mem_waddr         = wr_ptr_q[PW-2:0];
        mem_entry.data    = wr_data;
        mem_entry.be      = wr_be;
        mem_entry.last    = close;
        mem_entry.crc_off = close ? crc_tag(cfg_crc_off, crc_seen, wr_nocrc) : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_pkt    <= 1'b0;
            crc_seen  <= 1'b0;
            wr_ptr_q  <= '0;
            commit_q  <= '0;
            discard_q <= 1'b0;
        end else begin
            if (discard_q && clr_discard) begin
                discard_q <= 1'b0;
            end
            if (fail) begin
                wr_ptr_q  <= commit_q;
                in_pkt    <= 1'b0;
                crc_seen  <= 1'b0;
                discard_q <= 1'b1;
            end else if (store) begin
                wr_ptr_q <= wr_ptr_q + 1'b1;
                if (close) begin
                    commit_q <= wr_ptr_q + 1'b1;
                    in_pkt   <= 1'b0;
                    crc_seen <= 1'b0;
                end else begin
                    in_pkt   <= 1'b1;
                    crc_seen <= crc_seen | wr_nocrc;
                end
            end else if (open_cyc && wr_nocrc) begin
                crc_seen <= 1'b1;
            end
        end
    end

    assign wr_ptr     = wr_ptr_q;
    assign commit_ptr = commit_q;
    assign discard    = discard_q;

endmodule

// File: rtl/txpkt_rd_ctrl.sv
module txpkt_rd_ctrl #(
    parameter int DEPTH = 64,
    parameter int PW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [PW-1:0] commit_ptr,
    output logic          rd_valid,
    output logic [PW-1:0] rd_ptr,
    output logic [PW-2:0] mem_raddr
);

    logic [PW-1:0] rd_ptr_q;
    logic          avail;

    assign avail = (rd_ptr_q != commit_ptr);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr_q <= '0;
        end else if (rd_en && avail) begin
            rd_ptr_q <= rd_ptr_q + 1'b1;
        end
    end

    assign rd_valid  = avail;
    assign rd_ptr    = rd_ptr_q;
    assign mem_raddr = rd_ptr_q[PW-2:0];

endmodule

// File: rtl/txpkt_level.sv
module txpkt_level #(
    parameter int DEPTH = 64,
    parameter int PW    = $clog2(DEPTH) + 1,
    parameter int SPACE_MIN = 2
) (
    input  logic [PW-1:0] wr_ptr,
    input  logic [PW-1:0] rd_ptr,
    input  logic [PW-1:0] ready_thresh,
    output logic [PW-1:0] used,
    output logic          full,
    output logic          tx_ready,
    output logic          space_avail
);

    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0] SPACE_P = PW'(SPACE_MIN);

    logic [PW-1:0] free_words;

    always_comb begin
        used        = wr_ptr - rd_ptr;
        free_words  = DEPTH_P - used;
        full        = (used == DEPTH_P);
        tx_ready    = (free_words > ready_thresh);
        space_avail = (free_words > SPACE_P);
    end

endmodule

// File: rtl/txpkt_fifo.sv
module txpkt_fifo
    import txpkt_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int PW    = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_crc_off,
    input  logic [PW-1:0]     ready_thresh,
    input  logic              clr_discard,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BE_W-1:0]   wr_be,
    input  logic              wr_eof,
    input  logic              wr_nocrc,
    input  logic              wr_err,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [BE_W-1:0]   rd_be,
    output logic              rd_last,
    output logic              rd_crc_off,
    output logic              tx_ready,
    output logic              space_avail,
    output logic              discard
);

    logic          mem_we;
    logic [PW-2:0] mem_waddr;
    logic [PW-2:0] mem_raddr;
    entry_t        wentry;
    entry_t        rentry;
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] commit_ptr;
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] used;
    logic          full;

    txpkt_wr_ctrl #(.DEPTH(DEPTH), .PW(PW)) u_wr (
        .clk         (clk),
        .rst         (rst),
        .cfg_crc_off (cfg_crc_off),
        .clr_discard (clr_discard),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .wr_be       (wr_be),
        .wr_eof      (wr_eof),
        .wr_nocrc    (wr_nocrc),
        .wr_err      (wr_err),
        .full        (full),
        .mem_we      (mem_we),
        .mem_waddr   (mem_waddr),
        .mem_entry   (wentry),
        .wr_ptr      (wr_ptr),
        .commit_ptr  (commit_ptr),
        .discard     (discard)
    );

    txpkt_store #(.DEPTH(DEPTH), .AW(PW-1)) u_store (
        .clk    (clk),
        .we     (mem_we),
        .waddr  (mem_waddr),
        .wentry (wentry),
        .raddr  (mem_raddr),
        .rentry (rentry)
    );

    txpkt_rd_ctrl #(.DEPTH(DEPTH), .PW(PW)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .rd_en      (rd_en),
        .commit_ptr (commit_ptr),
        .rd_valid   (rd_valid),
        .rd_ptr     (rd_ptr),
        .mem_raddr  (mem_raddr)
    );

    txpkt_level #(.DEPTH(DEPTH), .PW(PW), .SPACE_MIN(2)) u_level (
        .wr_ptr       (wr_ptr),
        .rd_ptr       (rd_ptr),
        .ready_thresh (ready_thresh),
        .used         (used),
        .full         (full),
        .tx_ready     (tx_ready),
        .space_avail  (space_avail)
    );

    assign rd_data    = rentry.data;
    assign rd_be      = rentry.be;
    assign rd_last    = rentry.last;
    assign rd_crc_off = rentry.crc_off;

endmodule

// File: rtl/txpkt_fifo_chk.sv
module txpkt_fifo_chk #(
    parameter int DEPTH = 64,
    parameter int PW    = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          discard,
    input logic          clr_discard,
    input logic          rd_en,
    input logic          rd_valid,
    input logic [PW-1:0] wr_ptr,
    input logic [PW-1:0] commit_ptr,
    input logic [PW-1:0] rd_ptr,
    input logic [PW-1:0] used
);

    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    // flush lands the write position on the last frame boundary
    assert_flush_to_commit_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(discard) |-> (wr_ptr == commit_ptr));

    assert_locked_writes_R6: assert property (@(posedge clk) disable iff (rst)
        discard |=> ($stable(wr_ptr) && $stable(commit_ptr)));

    assert_flag_held_R6: assert property (@(posedge clk) disable iff (rst)
        (discard && !clr_discard) |=> discard);

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        used <= DEPTH_P);

    assert_pop_advances_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_valid) |=> (rd_ptr == $past(rd_ptr) + 1'b1));

endmodule

bind txpkt_fifo txpkt_fifo_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .discard     (discard),
    .clr_discard (clr_discard),
    .rd_en       (rd_en),
    .rd_valid    (rd_valid),
    .wr_ptr      (wr_ptr),
    .commit_ptr  (commit_ptr),
    .rd_ptr      (rd_ptr),
    .used        (used)
);

// File: tb/txpkt_fifo_tb.sv
`timescale 1ns/1ps
module txpkt_fifo_tb;

    localparam int DEPTH = 8;
    localparam int PW    = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_crc_off = 1'b0;
    logic [PW-1:0] ready_thresh = '0;
    logic          clr_discard = 1'b0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [3:0]    wr_be = '0;
    logic          wr_eof = 1'b0;
    logic          wr_nocrc = 1'b0;
    logic          wr_err = 1'b0;
    logic          rd_en = 1'b0;
    logic          rd_valid;
    logic [31:0]   rd_data;
    logic [3:0]    rd_be;
    logic          rd_last;
    logic          rd_crc_off;
    logic          tx_ready;
    logic          space_avail;
    logic          discard;

    always #4 clk = ~clk;

    txpkt_fifo #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .cfg_crc_off(cfg_crc_off), .ready_thresh(ready_thresh),
        .clr_discard(clr_discard), .wr_en(wr_en), .wr_data(wr_data), .wr_be(wr_be),
        .wr_eof(wr_eof), .wr_nocrc(wr_nocrc), .wr_err(wr_err), .rd_en(rd_en),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_be(rd_be), .rd_last(rd_last),
        .rd_crc_off(rd_crc_off), .tx_ready(tx_ready), .space_avail(space_avail),
        .discard(discard)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model: {crc_off, last, be, data}
    logic [37:0] exp_q[$];
    logic [37:0] pend_q[$];
    bit in_m = 0, crc_m = 0, disc_m = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic int free_m();
        return DEPTH - exp_q.size() - pend_q.size();
    endfunction

    // called in the low phase of the clock
    task automatic levels(input string req);
        for (int t = 0; t <= DEPTH; t++) begin
            ready_thresh = PW'(t);
            #0.1;
            chk({req, " R7 tx_ready"}, 64'(tx_ready), 64'(free_m() > t));
        end
        ready_thresh = '0;
        #0.1;
        chk({req, " R8 space_avail"}, 64'(space_avail), 64'(free_m() > 2));
        chk({req, " R6 discard"}, 64'(discard), 64'(disc_m));
        chk({req, " R3 rd_valid"}, 64'(rd_valid), 64'(exp_q.size() > 0));
    endtask

    task automatic cyc(input bit wen, input logic [31:0] d, input logic [3:0] be,
                       input bit eof, input bit nocrc, input bit err,
                       input bit clr, input bit ren);
        bit act, take, full, fail;
        wr_en = wen; wr_data = d; wr_be = be; wr_eof = eof;
        wr_nocrc = nocrc; wr_err = err; clr_discard = clr; rd_en = ren;
        #0.5;
        if (ren) begin
            chk("R10 rd_valid at pop", 64'(rd_valid), 64'(exp_q.size() > 0));
            if (exp_q.size() > 0) begin
                chk("R2 rd_data", 64'(rd_data), 64'(exp_q[0][31:0]));
                chk("R2 rd_be", 64'(rd_be), 64'(exp_q[0][35:32]));
                chk("R3 rd_last", 64'(rd_last), 64'(exp_q[0][36]));
                chk("R4 rd_crc_off", 64'(rd_crc_off), 64'(exp_q[0][37]));
            end
        end
        @(posedge clk);
        act  = !disc_m && (in_m || (wen && eof));
        take = !disc_m && wen && (in_m || eof);
        full = (exp_q.size() + pend_q.size()) == DEPTH;
        fail = act && (err || (take && full));
        if (ren && exp_q.size() > 0) void'(exp_q.pop_front());
        if (disc_m && clr) disc_m = 0;
        if (fail) begin
            pend_q.delete(); in_m = 0; crc_m = 0; disc_m = 1;
        end else if (take) begin
            if (in_m && eof) begin
                pend_q.push_back({(cfg_crc_off | crc_m | nocrc), 1'b1, be, d});
                foreach (pend_q[i]) exp_q.push_back(pend_q[i]);
                pend_q.delete(); in_m = 0; crc_m = 0;
            end else begin
                pend_q.push_back({1'b0, 1'b0, be, d});
                in_m = 1; crc_m = crc_m | nocrc;
            end
        end else if (act && nocrc) begin
            crc_m = 1;
        end
        @(negedge clk);
        wr_en = 0; wr_err = 0; wr_nocrc = 0; wr_eof = 0; clr_discard = 0; rd_en = 0;
    endtask

    function automatic logic [31:0] dat(input int a, input int b);
        return 32'hA500_0000 ^ (a << 16) ^ (b << 4) ^ (b * 3 + a);
    endfunction

    // nocrc_pos: word index with nocrc, -1 none, -2 on an idle mid-frame cycle
    task automatic pkt(input int len, input int nocrc_pos, input int tag);
        for (int i = 0; i < len; i++) begin
            if (i == len - 1 && exp_q.size() == 0)
                chk("R3 frame hidden before closing word", 64'(rd_valid), 64'd0);
            if (nocrc_pos == -2 && i == 1) cyc(0, '0, '0, 0, 1, 0, 0, 0);
            cyc(1, dat(tag, i), 4'(i * 5 + len), (i == 0 || i == len - 1),
                (i == nocrc_pos), 0, 0, 0);
        end
    endtask

    task automatic drain();
        while (exp_q.size() > 0) cyc(0, '0, '0, 0, 0, 0, 0, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0.5;
        // R1 reset state
        chk("R1 rd_valid", 64'(rd_valid), 64'd0);
        chk("R1 discard", 64'(discard), 64'd0);
        levels("R1");

        // R3 stray word while idle is ignored
        cyc(1, 32'hDEAD_BEEF, 4'hF, 0, 0, 0, 0, 0);
        levels("R3 stray");

        // R2 R3 R4 sweep of length, CRC request position and config bit
        for (int cfg = 0; cfg < 2; cfg++) begin
            cfg_crc_off = cfg[0];
            for (int len = 2; len <= 5; len++) begin
                for (int pos = -2; pos < len; pos++) begin
                    pkt(len, pos, len * 16 + pos + 2 + cfg * 128);
                    levels("R4 sweep");
                    drain();
                end
            end
        end
        cfg_crc_off = 1'b0;

        // R5 R6 flush of an open frame behind a complete one
        pkt(3, -1, 200);
        cyc(1, dat(201, 0), 4'h3, 1, 0, 0, 0, 0);
        cyc(1, dat(201, 1), 4'h7, 0, 0, 0, 0, 0);
        levels("R5 before flush");
        cyc(1, dat(201, 2), 4'hF, 0, 0, 1, 0, 0);
        levels("R5 after flush");
        pkt(2, -1, 202);
        levels("R6 locked");
        cyc(1, dat(203, 0), 4'hF, 1, 0, 0, 1, 0);
        levels("R6 clear with write");
        pkt(2, 0, 204);
        levels("R6 after clear");
        drain();

        // R10 flush and pop in one cycle
        pkt(2, -1, 210);
        cyc(1, dat(211, 0), 4'h1, 1, 0, 0, 0, 0);
        cyc(1, dat(211, 1), 4'h2, 0, 0, 0, 0, 0);
        cyc(0, '0, '0, 0, 0, 1, 0, 1);
        levels("R10 flush with pop");
        cyc(0, '0, '0, 0, 0, 0, 1, 0);
        drain();
        levels("R10 drained");

        // R9 frame that fits exactly, then one that overflows
        pkt(DEPTH, 3, 220);
        levels("R9 exact fill");
        drain();
        pkt(DEPTH + 2, -1, 221);
        levels("R9 overflow");
        cyc(0, '0, '0, 0, 0, 0, 1, 0);
        pkt(2, -1, 222);
        levels("R9 recovered");
        drain();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule